// File: doc/BRIEF.md
# Video Output Data-Valid Generator

This block drives the pixel data-valid strobe on a video decoder's output port. The strobe's shape depends on the output format class and on two control bits. The narrow class covers the byte-wide YCbCr formats, including the embedded-sync byte stream. The wide class covers the 16-bit YCbCr, 15-bit RGB and 16-bit RGB formats. In the wide class the strobe is either a square wave with a 50/50 duty cycle at the pixel rate or a copy of the line-locked pixel strobe. It is gated either by the active-video window or by nothing. In the narrow class the strobe follows the pixel-rate enable inside the active window, and it can also be qualified by the phase of the doubled pixel clock.

The block also freezes the output timing in step with the fields. A freeze request waits for the end of the current field. A release request waits for the start of the next field. While frozen, data-valid is held low and the frozen flag is high.

Every output is registered. Data-valid after a rising clock edge reflects the inputs sampled at that edge.

Top module: `vid_dvalid_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first qualifying input, `dvalid` and `frozen` are both low.
- R2: In a wide format (code 2, 3 or 4) with `cfg_duty`=0 and `cfg_linetime`=0, `dvalid` equals an internal wave register ANDed with `act_video` and `act_line`. At an edge where `act_video` is high and was low at the previous edge, the wave is cleared to 0. At any other edge where `pix_en` is high, the wave inverts.
- R3: In a wide format with `cfg_duty`=1, `dvalid` after an edge equals `lock_strobe` at that edge, gated as set by `cfg_linetime`.
- R4: In a wide format with `cfg_linetime`=1, `act_video` and `act_line` do not gate `dvalid`.
- R5: In a narrow format (code 0 or 1) with `cfg_linetime`=0, `dvalid` equals `pix_en & act_video & act_line`, whatever the value of `cfg_duty`.
- R6: In a narrow format with `cfg_linetime`=1, `dvalid` equals `pix_en & act_video & act_line & clk2_phase`.
- R7: `fmt_sel` codes 0 and 1 select the narrow behaviour. Every other code, including 5 to 7, selects the wide behaviour.
- R8: When `cfg_freeze` is high while running, `frozen` rises, and `dvalid` is forced low, only after an edge at which `field_end` is high.
- R9: When `cfg_freeze` is low while frozen, `frozen` falls only after an edge at which `field_start` is high. Normal `dvalid` resumes from that same edge.
- R10: While frozen, the wave register holds its value. After release it continues from the held phase.
- R11: A `field_start` pulse while running and a `field_end` pulse while frozen do not change `frozen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | FMT_W | Output format code |
| pix_en | input | 1 | Pixel-rate enable |
| lock_strobe | input | 1 | Line-locked pixel strobe |
| act_video | input | 1 | Active video portion of the line |
| act_line | input | 1 | Line lies inside the active region |
| field_start | input | 1 | One-cycle pulse at the first cycle of a field |
| field_end | input | 1 | One-cycle pulse at the last cycle of a field |
| clk2_phase | input | 1 | Phase of the doubled pixel clock |
| cfg_duty | input | 1 | Wide-format source: 0 square wave, 1 line-locked strobe |
| cfg_linetime | input | 1 | Wide: 1 ungated; narrow: 1 AND with clk2_phase |
| cfg_freeze | input | 1 | Freeze request |
| dvalid | output | 1 | Data-valid strobe |
| frozen | output | 1 | Output timing is frozen |

## Verification
A freeze state machine stuck in the wrong state shows up as `frozen` disagreeing with the last field pulse within one clock. It also shows as `dvalid` staying low during a whole active field, or pulsing during a frozen one. A wave register with the wrong phase shows up on the first wide-format active line as a square wave that starts high, or that keeps toggling during a freeze. A wrong format decode shows up as soon as a code-by-code sweep puts `pix_en` and `lock_strobe` at different values. Every scenario compares each cycle's outputs against a cycle model built from the requirements, so a divergence is reported in the cycle it appears.

// File: rtl/vdv_pkg.sv
package vdv_pkg;

   typedef enum logic {
      FRZ_RUN  = 1'b0,
      FRZ_HOLD = 1'b1
   } frz_state_e;

   typedef struct packed {
      logic pix;
      logic strobe;
      logic video;
      logic line;
      logic c2;
   } vdv_timing_t;

endpackage

// File: rtl/vdv_fmt_decode.sv
module vdv_fmt_decode #(
   parameter int unsigned FMT_W = 3,
   parameter logic [(1<<FMT_W)-1:0] NARROW_MASK = 'b11
) (
   input  logic [FMT_W-1:0] fmt_sel,
   output logic             is_narrow
);
   localparam int unsigned NCODES = 1 << FMT_W;

   logic [NCODES-1:0] code_hit;

   generate
      if (FMT_W < 1 || FMT_W > 4) begin : g_bad_w
         $error("vdv_fmt_decode: FMT_W out of range");
      end
      if (NARROW_MASK == '0) begin : g_bad_mask
         $error("vdv_fmt_decode: NARROW_MASK selects no code");
      end
      for (genvar c = 0; c < NCODES; c++) begin : g_code
         if (NARROW_MASK[c]) begin : g_on
            assign code_hit[c] = (fmt_sel == FMT_W'(c));
         end else begin : g_off
            assign code_hit[c] = 1'b0;
         end
      end
   endgenerate

   assign is_narrow = |code_hit;

endmodule

// File: rtl/vdv_freeze_ctl.sv
module vdv_freeze_ctl
   import vdv_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_freeze,
   input  logic field_start,
   input  logic field_end,
   output logic hold_next,
   output logic frozen
);
   frz_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         FRZ_RUN:  if (cfg_freeze && field_end)    st_d = FRZ_HOLD;
         FRZ_HOLD: if (!cfg_freeze && field_start) st_d = FRZ_RUN;
         default:  st_d = FRZ_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= FRZ_RUN;
      else        st_q <= st_d;
   end

   assign hold_next = (st_d == FRZ_HOLD);
   assign frozen    = (st_q == FRZ_HOLD);

endmodule

// File: rtl/vdv_wave_gen.sv
module vdv_wave_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic act_video,
   input  logic pix_en,
   input  logic hold,
   output logic wave_next
);
   logic wave_q;
   logic video_q;
   logic seg_start;

   assign seg_start = act_video && !video_q;

   always_comb begin
      wave_next = wave_q;
      if (!hold) begin
         if (seg_start)   wave_next = 1'b0;
         else if (pix_en) wave_next = !wave_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wave_q  <= 1'b0;
         video_q <= 1'b0;
      end else begin
         wave_q  <= wave_next;
         video_q <= act_video;
      end
   end

endmodule

// File: rtl/vid_dvalid_gen.sv
module vid_dvalid_gen
   import vdv_pkg::*;
#(
   parameter int unsigned FMT_W = 3,
   parameter logic [(1<<FMT_W)-1:0] NARROW_MASK = 'b11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [FMT_W-1:0] fmt_sel,
   input  logic             pix_en,
   input  logic             lock_strobe,
   input  logic             act_video,
   input  logic             act_line,
   input  logic             field_start,
   input  logic             field_end,
   input  logic             clk2_phase,
   input  logic             cfg_duty,
   input  logic             cfg_linetime,
   input  logic             cfg_freeze,
   output logic             dvalid,
   output logic             frozen
);
   vdv_timing_t tin;
   logic        narrow;
   logic        hold_next;
   logic        wave_next;
   logic        wide_raw;
   logic        narrow_raw;
   logic        raw;
   logic        dvalid_q;

   assign tin = '{pix: pix_en, strobe: lock_strobe, video: act_video,
                  line: act_line, c2: clk2_phase};

   vdv_fmt_decode #(.FMT_W(FMT_W), .NARROW_MASK(NARROW_MASK)) u_fmt (
      .fmt_sel   (fmt_sel),
      .is_narrow (narrow)
   );

   vdv_freeze_ctl u_frz (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_freeze  (cfg_freeze),
      .field_start (field_start),
      .field_end   (field_end),
      .hold_next   (hold_next),
      .frozen      (frozen)
   );

   vdv_wave_gen u_wave (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_video (tin.video),
      .pix_en    (tin.pix),
      .hold      (hold_next),
      .wave_next (wave_next)
   );

   always_comb begin
      wide_raw   = (cfg_duty ? tin.strobe : wave_next)
                 & (cfg_linetime | (tin.video & tin.line));
      narrow_raw = tin.pix & tin.video & tin.line & (!cfg_linetime | tin.c2);
      raw        = narrow ? narrow_raw : wide_raw;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) dvalid_q <= 1'b0;
      else        dvalid_q <= raw & !hold_next;
   end

   assign dvalid = dvalid_q;

endmodule

// File: rtl/vdv_checker.sv
module vdv_checker #(
   parameter int unsigned FMT_W = 3,
   parameter logic [(1<<FMT_W)-1:0] NARROW_MASK = 'b11
) (
   input logic             clk,
   input logic             rst_n,
   input logic [FMT_W-1:0] fmt_sel,
   input logic             pix_en,
   input logic             lock_strobe,
   input logic             act_video,
   input logic             act_line,
   input logic             field_start,
   input logic             field_end,
   input logic             clk2_phase,
   input logic             cfg_duty,
   input logic             cfg_linetime,
   input logic             cfg_freeze,
   input logic             dvalid,
   input logic             frozen
);
   logic nar;
   assign nar = NARROW_MASK[fmt_sel];

   AST_RST_QUIET: assert property (@(posedge clk) !rst_n |=> (!dvalid && !frozen)); // R1

   AST_WIDE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (dvalid && $past(!nar && !cfg_linetime)) |-> $past(act_video && act_line)); // R2

   AST_STROBE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (dvalid && $past(!nar && cfg_duty)) |-> $past(lock_strobe)); // R3

   AST_NARROW_PIX: assert property (@(posedge clk) disable iff (!rst_n)
      (dvalid && $past(nar)) |-> $past(pix_en && act_video && act_line)); // R5

   AST_NARROW_C2: assert property (@(posedge clk) disable iff (!rst_n)
      (dvalid && $past(nar && cfg_linetime)) |-> $past(clk2_phase)); // R6

   AST_FREEZE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frozen) |-> $past(field_end && cfg_freeze)); // R8

   AST_FROZEN_NO_DV: assert property (@(posedge clk) disable iff (!rst_n)
      frozen |-> !dvalid); // R8

   AST_RESUME_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frozen) |-> $past(field_start && !cfg_freeze)); // R9

endmodule

bind vid_dvalid_gen vdv_checker #(.FMT_W(FMT_W), .NARROW_MASK(NARROW_MASK)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .fmt_sel      (fmt_sel),
   .pix_en       (pix_en),
   .lock_strobe  (lock_strobe),
   .act_video    (act_video),
   .act_line     (act_line),
   .field_start  (field_start),
   .field_end    (field_end),
   .clk2_phase   (clk2_phase),
   .cfg_duty     (cfg_duty),
   .cfg_linetime (cfg_linetime),
   .cfg_freeze   (cfg_freeze),
   .dvalid       (dvalid),
   .frozen       (frozen)
);

// File: tb/sim_vid_dvalid_gen.sv
`timescale 1ns/1ps
module sim_vid_dvalid_gen;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [2:0] fmt_sel;
   logic       pix_en, lock_strobe, act_video, act_line;
   logic       field_start, field_end, clk2_phase;
   logic       cfg_duty, cfg_linetime, cfg_freeze;
   logic       dvalid, frozen;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   logic [15:0] lf = 16'hACE1;

   always #4 clk = ~clk;

   vid_dvalid_gen u0 (
      .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .pix_en(pix_en),
      .lock_strobe(lock_strobe), .act_video(act_video), .act_line(act_line),
      .field_start(field_start), .field_end(field_end), .clk2_phase(clk2_phase),
      .cfg_duty(cfg_duty), .cfg_linetime(cfg_linetime), .cfg_freeze(cfg_freeze),
      .dvalid(dvalid), .frozen(frozen)
   );

   // cycle model built from the requirements
   logic m_frz, m_wave, m_vq, m_dv;
   always @(posedge clk) begin
      logic nx_frz, nx_wave, narrow, raw;
      if (!rst_n) begin
         m_frz <= 0; m_wave <= 0; m_vq <= 0; m_dv <= 0;
      end else begin
         nx_frz = m_frz;
         if (!m_frz && cfg_freeze && field_end)   nx_frz = 1;
         if (m_frz && !cfg_freeze && field_start) nx_frz = 0;
         nx_wave = m_wave;
         if (!nx_frz) begin
            if (act_video && !m_vq) nx_wave = 0;
            else if (pix_en)        nx_wave = !m_wave;
         end
         narrow = (fmt_sel == 3'd0) || (fmt_sel == 3'd1);
         if (narrow)
            raw = pix_en && act_video && act_line && (!cfg_linetime || clk2_phase);
         else
            raw = (cfg_duty ? lock_strobe : nx_wave) && (cfg_linetime || (act_video && act_line));
         m_dv   <= raw && !nx_frz;
         m_frz  <= nx_frz;
         m_wave <= nx_wave;
         m_vq   <= act_video;
      end
   end

   function automatic logic rbit();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      return lf[0];
   endfunction

   task automatic check(string tag, logic exp_dv, logic exp_fz);
      checks++;
      if (dvalid !== exp_dv || frozen !== exp_fz) begin
         failures++;
         $display("FAIL %s: dvalid=%b frozen=%b expected dvalid=%b frozen=%b at %0t",
                  tag, dvalid, frozen, exp_dv, exp_fz, $time);
      end
   endtask

   // drive at negedge, let one edge pass, check at next negedge
   task automatic step(string tag, logic pe, logic ls, logic av, logic al,
                       logic fs, logic fe, logic c2);
      pix_en = pe; lock_strobe = ls; act_video = av; act_line = al;
      field_start = fs; field_end = fe; clk2_phase = c2;
      @(posedge clk); @(negedge clk);
      check(tag, m_dv, m_frz);
   endtask

   task automatic rstep(string tag, logic fs, logic fe);
      step(tag, rbit(), rbit(), rbit() | rbit(), rbit() | rbit(), fs, fe, rbit());
   endtask

   task automatic t_reset();
      rst_n = 0;
      repeat (3) @(negedge clk);
      check("R1", 1'b0, 1'b0);
      rst_n = 1;
      step("R1", 0, 0, 0, 0, 0, 0, 0);
      check("R1", 1'b0, 1'b0);
   endtask

   task automatic t_wide_square();
      fmt_sel = 3'd2; cfg_duty = 0; cfg_linetime = 0;
      repeat (3) step("R2", 1, 0, 0, 1, 0, 0, 0);
      step("R2", 1, 0, 1, 1, 0, 0, 0);
      check("R2 wave cleared at segment start", 1'b0, 1'b0);
      step("R2", 1, 0, 1, 1, 0, 0, 0);
      check("R2 wave toggles", 1'b1, 1'b0);
      for (int i = 0; i < 10; i++) step("R2", 1, 0, 1, 1, 0, 0, 0);
      for (int i = 0; i < 20; i++) step("R2", rbit(), 0, 1, rbit(), 0, 0, 0);
      for (int i = 0; i < 40; i++) rstep("R2", 0, 0);
   endtask

   task automatic t_wide_strobe();
      fmt_sel = 3'd3; cfg_duty = 1;
      cfg_linetime = 0;
      for (int i = 0; i < 40; i++) rstep("R3", 0, 0);
      cfg_linetime = 1;
      for (int i = 0; i < 20; i++) rstep("R3", 0, 0);
   endtask

   task automatic t_wide_fullline();
      fmt_sel = 3'd4; cfg_linetime = 1;
      cfg_duty = 1;
      step("R4", 0, 1, 0, 0, 0, 0, 0);
      check("R4 ungated strobe", 1'b1, 1'b0);
      cfg_duty = 0;
      for (int i = 0; i < 30; i++) step("R4", 1, 0, 0, 0, 0, 0, 0);
      for (int i = 0; i < 30; i++) rstep("R4", 0, 0);
   endtask

   task automatic t_narrow_normal();
      cfg_linetime = 0;
      for (int f = 0; f < 2; f++) begin
         fmt_sel = 3'(f);
         cfg_duty = 0;
         for (int i = 0; i < 20; i++) rstep("R5", 0, 0);
         cfg_duty = 1;
         step("R5", 0, 1, 1, 1, 0, 0, 0);
         check("R5 duty ignored", 1'b0, 1'b0);
         for (int i = 0; i < 20; i++) rstep("R5", 0, 0);
      end
   endtask

   task automatic t_narrow_clk2();
      fmt_sel = 3'd1; cfg_linetime = 1;
      step("R6", 1, 0, 1, 1, 0, 0, 0);
      check("R6 low phase", 1'b0, 1'b0);
      step("R6", 1, 0, 1, 1, 0, 0, 1);
      check("R6 high phase", 1'b1, 1'b0);
      for (int i = 0; i < 30; i++) rstep("R6", 0, 0);
   endtask

   task automatic t_fmt_codes();
      cfg_duty = 1; cfg_linetime = 0;
      for (int f = 0; f < 8; f++) begin
         fmt_sel = 3'(f);
         step("R7", 1, 0, 1, 1, 0, 0, 0);
         check("R7 pix vs strobe", (f < 2) ? 1'b1 : 1'b0, 1'b0);
         step("R7", 0, 1, 1, 1, 0, 0, 0);
         check("R7 strobe vs pix", (f < 2) ? 1'b0 : 1'b1, 1'b0);
         for (int i = 0; i < 6; i++) rstep("R7", 0, 0);
      end
   endtask

   task automatic t_freeze();
      fmt_sel = 3'd2; cfg_duty = 0; cfg_linetime = 0; cfg_freeze = 1;
      for (int i = 0; i < 8; i++) step("R8 waits for field end", 1, 0, 1, 1, 0, 0, 0);
      check("R8 not yet frozen", m_dv, 1'b0);
      step("R8", 1, 0, 1, 1, 0, 1, 0);
      check("R8 frozen at field end", 1'b0, 1'b1);
      for (int i = 0; i < 15; i++) step("R10 wave held", 1, 1, 1, 1, 0, 0, 1);
      for (int i = 0; i < 15; i++) rstep("R8", 0, 0);
   endtask

   task automatic t_resume();
      logic held;
      cfg_freeze = 0;
      for (int i = 0; i < 6; i++) step("R9 waits for field start", 1, 0, 1, 1, 0, 0, 0);
      check("R9 still frozen", 1'b0, 1'b1);
      held = m_wave;
      step("R9", 1, 0, 1, 1, 1, 0, 0);
      check("R10 resumes from held phase", !held, 1'b0);
      for (int i = 0; i < 10; i++) step("R9", 1, 0, 1, 1, 0, 0, 0);
   endtask

   task automatic t_ignored();
      cfg_freeze = 1;
      for (int i = 0; i < 4; i++) begin
         step("R11 start while running", 1, 0, 1, 1, 1, 0, 0);
         check("R11 running", m_dv, 1'b0);
      end
      step("R11", 1, 0, 1, 1, 0, 1, 0);
      cfg_freeze = 0;
      for (int i = 0; i < 4; i++) begin
         step("R11 end while frozen", 1, 0, 1, 1, 0, 1, 0);
         check("R11 frozen", 1'b0, 1'b1);
      end
      step("R11", 1, 0, 1, 1, 1, 0, 0);
      check("R11 released", m_dv, 1'b0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      rst_n = 0; fmt_sel = 0; pix_en = 0; lock_strobe = 0; act_video = 0;
      act_line = 0; field_start = 0; field_end = 0; clk2_phase = 0;
      cfg_duty = 0; cfg_linetime = 0; cfg_freeze = 0;
      @(negedge clk);
      t_reset();
      t_wide_square();
      t_wide_strobe();
      t_wide_fullline();
      t_narrow_normal();
      t_narrow_clk2();
      t_fmt_codes();
      t_freeze();
      t_resume();
      t_ignored();
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

endmodule